// File: doc/BRIEF.md
# Direct-Mapped Cache Victim Buffer

This block is a small, fully associative store placed next to a direct-mapped cache. Every line the main cache discards is pushed into it together with its address tag, a dirty flag and its data. When the main cache misses, the same cycle's lookup searches all entries at once. A match hands the line back to the main cache, and no request leaves for the next level. Only when the buffer also misses is a next-level request raised. The buffer therefore gives extra associativity to the few sets that fight over one direct-mapped slot.

A victim hit that coincides with the main cache discarding the line it is about to refill is a swap: the returned entry's slot receives the discarded line in the same cycle. A victim hit with no discarded line frees the entry. A fresh insertion takes slots in a fixed rotation, so once the buffer is full the overwritten line is the one allocated longest ago. If that line is dirty, it is handed out on a write-back port in the cycle of the overwrite. The depth is meant to be 4 or 8 entries.

Top module: `victim_buffer`

## Requirements
- R1: After reset, and after any later reset, no entry is valid: a lookup does not hit, raises `nl_req`, and `wb_valid` stays low.
- R2: An insert (`ins_valid`) stores the tag, the dirty flag and the data. A later lookup of that tag, with no insert in the same cycle, returns `lk_hit`=1 with the stored `lk_dirty` and `lk_data` in the cycle of the lookup.
- R3: All entries are compared in parallel, so a line hits regardless of which slot holds it, including the last slot.
- R4: A lookup hit in the same cycle as an insert is a swap. The matching line is returned, and the inserted line takes its slot. The allocation rotation does not advance, `wb_valid` stays low even if the slot next in rotation holds a dirty line, and `nl_req` stays low.
- R5: A lookup hit with no insert frees the matching entry, so a repeat lookup of the same tag misses.
- R6: `nl_req` is high exactly when `lk_valid` is high and the buffer misses, and `nl_tag` then equals `lk_tag`.
- R7: Inserts that are not swaps fill slots in a rotation starting at slot 0 after reset, and they overwrite whatever the next slot holds. When the buffer is full, the line lost is the one allocated longest ago.
- R8: When a non-swap insert overwrites a valid entry whose dirty flag is set, `wb_valid` is high in that cycle with that entry's tag and data on `wb_tag`/`wb_data`. Overwriting a clean or empty entry leaves `wb_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | The main cache discards a line this cycle |
| ins_tag | input | TAG_W | Full line address of the discarded line |
| ins_dirty | input | 1 | Discarded line is modified |
| ins_data | input | DATA_W | Discarded line data |
| lk_valid | input | 1 | Main cache missed; probe the buffer |
| lk_tag | input | TAG_W | Line address being probed |
| lk_hit | output | 1 | Probe matched a valid entry |
| lk_dirty | output | 1 | Dirty flag of the matched line |
| lk_data | output | DATA_W | Data of the matched line (zero on a miss) |
| nl_req | output | 1 | Request the line from the next level |
| nl_tag | output | TAG_W | Line address of that request |
| wb_valid | output | 1 | A dirty line is being overwritten |
| wb_tag | output | TAG_W | Line address of the overwritten dirty line |
| wb_data | output | DATA_W | Data of the overwritten dirty line |

## Verification
The main function is driven by a cold probe, a fill of partly empty buffers, probes that take a line out, swaps, and a wrap of the rotation over a full buffer with a mix of clean and dirty occupants. Probing a line again after it was taken tells freeing apart from keeping. A swap made while the slot next in rotation is dirty tells a swap apart from an allocation, because only an allocation may produce a write-back. The overwrite sequence after the wrap shows that allocation order, not use, picks the lost line, and that a write-back appears only for dirty lines.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // next position of the allocation rotation over n slots
  function automatic int unsigned vb_rot_next(input int unsigned cur, input int unsigned n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction

  // an overwrite must be written back when the slot holds a live modified line
  function automatic logic vb_needs_wb(input logic live, input logic modified);
    return live & modified;
  endfunction
endpackage

// File: rtl/vb_match.sv
module vb_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENTRIES-1:0]            live,
  input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]              probe,
  output logic [ENTRIES-1:0]            match_vec,
  output logic                          any_match,
  output logic [$clog2(ENTRIES)-1:0]    match_idx
);
  localparam int IDX_W = $clog2(ENTRIES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = live[g] && (tags[g] == probe);
  end

  assign any_match = |match_vec;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_idx = IDX_W'(i);
    end
  end

  // tags held in the buffer are unique, so at most one comparator fires
  p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));
endmodule

// File: rtl/vb_alloc.sv
module vb_alloc #(
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step,
  output logic [$clog2(ENTRIES)-1:0] slot
);
  import vb_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (step) slot_q <= IDX_W'(vb_rot_next(int'(slot_q), ENTRIES));
  end

  assign slot = slot_q;

  // swaps and idle cycles leave the rotation where it is
  p_hold_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(slot_q));
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 26,
  parameter int DATA_W  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic              ins_dirty,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              lk_valid,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic              lk_dirty,
  output logic [DATA_W-1:0] lk_data,
  output logic              nl_req,
  output logic [TAG_W-1:0]  nl_tag,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data
);
  import vb_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             live_q;
  logic [ENTRIES-1:0]             mod_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_q;
  logic [ENTRIES-1:0][DATA_W-1:0] data_q;

  logic [ENTRIES-1:0] match_vec;
  logic               any_match;
  logic [IDX_W-1:0]   match_idx;
  logic [IDX_W-1:0]   rot_slot;

  // named internal events
  logic             probe_hit;
  logic             swap_ev;
  logic             take_ev;
  logic             alloc_ev;
  logic             spill_ev;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  vb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) i_match (
    .clk(clk), .rst_n(rst_n), .live(live_q), .tags(tag_q), .probe(lk_tag),
    .match_vec(match_vec), .any_match(any_match), .match_idx(match_idx)
  );

  assign probe_hit = lk_valid && any_match;
  assign swap_ev   = probe_hit && ins_valid;
  assign take_ev   = probe_hit && !ins_valid;
  assign alloc_ev  = ins_valid && !swap_ev;
  assign spill_ev  = alloc_ev && vb_needs_wb(live_q[rot_slot], mod_q[rot_slot]);
  assign wr_en     = swap_ev || alloc_ev;
  assign wr_idx    = swap_ev ? match_idx : rot_slot;

  vb_alloc #(.ENTRIES(ENTRIES)) i_alloc (
    .clk(clk), .rst_n(rst_n), .step(alloc_ev), .slot(rot_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      mod_q  <= '0;
    end else if (wr_en) begin
      live_q[wr_idx] <= 1'b1;
      mod_q[wr_idx]  <= ins_dirty;
    end else if (take_ev) begin
      live_q[match_idx] <= 1'b0;
      mod_q[match_idx]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= ins_tag;
      data_q[wr_idx] <= ins_data;
    end
  end

  assign lk_hit   = probe_hit;
  assign lk_dirty = probe_hit && mod_q[match_idx];
  assign lk_data  = probe_hit ? data_q[match_idx] : '0;
  assign nl_req   = lk_valid && !any_match;
  assign nl_tag   = lk_tag;
  assign wb_valid = spill_ev;
  assign wb_tag   = tag_q[rot_slot];
  assign wb_data  = data_q[rot_slot];

  p_alloc_stores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ev |=> live_q[$past(rot_slot)] && tag_q[$past(rot_slot)] == $past(ins_tag)
                 && mod_q[$past(rot_slot)] == $past(ins_dirty));

  p_swap_refills_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_ev |=> live_q[$past(match_idx)] && tag_q[$past(match_idx)] == $past(ins_tag));

  p_take_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> !live_q[$past(match_idx)]);

  p_spill_needs_insert_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ins_valid && !lk_hit);
endmodule

// File: tb/test_victim_buffer.sv
module test_victim_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 20;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0, ins_dirty = 1'b0, lk_valid = 1'b0;
  logic [TW-1:0] ins_tag = '0, lk_tag = '0;
  logic [DW-1:0] ins_data = '0;
  logic          lk_hit, lk_dirty, nl_req, wb_valid;
  logic [DW-1:0] lk_data, wb_data;
  logic [TW-1:0] nl_tag, wb_tag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  victim_buffer #(.ENTRIES(4), .TAG_W(TW), .DATA_W(DW)) i_victim_buffer (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_dirty(ins_dirty), .ins_data(ins_data),
    .lk_valid(lk_valid), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_dirty(lk_dirty), .lk_data(lk_data),
    .nl_req(nl_req), .nl_tag(nl_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data)
  );

  // line data is derived from the tag so every line is recognisable
  function automatic logic [DW-1:0] line_of(input logic [TW-1:0] t);
    return {t[15:0], ~t[15:0]};
  endfunction

  typedef struct packed {
    logic          iv;
    logic          id;
    logic [TW-1:0] it;
    logic          lv;
    logic [TW-1:0] lt;
    logic          eh;
    logic          ed;
    logic          en;
    logic          ew;
    logic [TW-1:0] et;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00100, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // cold probe, R6
    '{1'b1, 1'b0, 20'h00A01, 1'b1, 20'h00B00, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // A -> slot0, R7
    '{1'b1, 1'b1, 20'h00A02, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // B -> slot1
    '{1'b1, 1'b0, 20'h00A03, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // C -> slot2
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00A01, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0},     // take A, R2
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00A01, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // A gone, R5
    '{1'b1, 1'b1, 20'h00A04, 1'b1, 20'h00A02, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0},     // swap B<->D, R4
    '{1'b1, 1'b0, 20'h00A05, 1'b1, 20'h00A04, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0},     // swap D<->E, R4
    '{1'b1, 1'b1, 20'h00A06, 1'b1, 20'h00C00, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // F -> slot3
    '{1'b1, 1'b1, 20'h00A07, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // G -> empty slot0
    '{1'b1, 1'b0, 20'h00A08, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // H over clean E, R8
    '{1'b1, 1'b0, 20'h00A09, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0},     // I over clean C
    '{1'b1, 1'b0, 20'h00A0A, 1'b0, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b1, 20'h00A06}, // J over dirty F, R8
    '{1'b1, 1'b1, 20'h00A0B, 1'b1, 20'h00D00, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00A07}, // K over dirty G, R7
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00A05, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0},     // E lost, R7
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00A0B, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0},     // K in slot0, R3
    '{1'b0, 1'b0, 20'h00000, 1'b1, 20'h00A0A, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0}      // J in last slot, R3
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // drive one cycle's stimulus at the falling edge, check the combinational
  // outputs before the rising edge commits the update
  task automatic step(input vec_t v);
    @(negedge clk);
    ins_valid = v.iv; ins_dirty = v.id; ins_tag = v.it; ins_data = line_of(v.it);
    lk_valid  = v.lv; lk_tag = v.lt;
    #1;
    check(lk_hit == v.eh, "R2", "lk_hit", 32'(lk_hit), 32'(v.eh));
    if (v.eh) begin
      check(lk_dirty == v.ed, "R2", "lk_dirty", 32'(lk_dirty), 32'(v.ed));
      check(lk_data == line_of(v.lt), "R2", "lk_data", lk_data, line_of(v.lt));
    end
    check(nl_req == v.en, "R6", "nl_req", 32'(nl_req), 32'(v.en));
    if (v.en) check(nl_tag == v.lt, "R6", "nl_tag", 32'(nl_tag), 32'(v.lt));
    check(wb_valid == v.ew, "R8", "wb_valid", 32'(wb_valid), 32'(v.ew));
    if (v.ew) begin
      check(wb_tag == v.et, "R8", "wb_tag", 32'(wb_tag), 32'(v.et));
      check(wb_data == line_of(v.et), "R8", "wb_data", wb_data, line_of(v.et));
    end
  endtask

  function automatic vec_t mk(input logic iv, input logic id, input logic [TW-1:0] it,
                              input logic lv, input logic [TW-1:0] lt,
                              input logic eh, input logic ed, input logic en,
                              input logic ew, input logic [TW-1:0] et);
    vec_t v;
    v = '{iv, id, it, lv, lt, eh, ed, en, ew, et};
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL timeout all-requirements actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset state seen at the ports while reset is held
    lk_valid = 1'b1; lk_tag = 20'h00A01;
    repeat (2) @(negedge clk);
    #1;
    check(lk_hit == 1'b0, "R1", "lk_hit in reset", 32'(lk_hit), 0);
    check(nl_req == 1'b1, "R1", "nl_req in reset", 32'(nl_req), 1);
    check(wb_valid == 1'b0, "R1", "wb_valid in reset", 32'(wb_valid), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R1: a later reset empties the buffer (H was valid)
    @(negedge clk);
    ins_valid = 1'b0; lk_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(mk(1'b0, 1'b0, 20'h0, 1'b1, 20'h00A08, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0));
    step(mk(1'b0, 1'b0, 20'h0, 1'b1, 20'h00A09, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0));

    // fill with dirty lines; rotation is back at slot0 (R7)
    for (int k = 0; k < 4; k++)
      step(mk(1'b1, 1'b1, 20'h01000 + TW'(k), 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0));
    // R4: swap while the next rotation slot is dirty -> no write-back
    step(mk(1'b1, 1'b1, 20'h01004, 1'b1, 20'h01002, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0));
    // R4: swapped-in line sits in the freed slot; taking it frees it (R5)
    step(mk(1'b0, 1'b0, 20'h0, 1'b1, 20'h01004, 1'b1, 1'b1, 1'b0, 1'b0, 20'h0));
    // R7: rotation did not move on the swap, so slot0 (oldest) is overwritten
    step(mk(1'b1, 1'b0, 20'h01005, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h01000));
    // R5: the taken line no longer hits
    step(mk(1'b0, 1'b0, 20'h0, 1'b1, 20'h01004, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0));
    // R8: next overwrite hits slot1 (dirty 01001)
    step(mk(1'b1, 1'b0, 20'h01006, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 20'h01001));
    // R8: next overwrite hits slot2, emptied by the take -> no write-back
    step(mk(1'b1, 1'b0, 20'h01007, 1'b0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 20'h0));

    @(negedge clk);
    ins_valid = 1'b0; lk_valid = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule